// File: doc/BRIEF.md
# Crossbar Evaluation Step Sequencer

This block is the control state machine that carries a resistive crossbar logic array through one full evaluation. A single-cycle start request, accepted only while the sequencer is idle, launches a fixed walk through seven phases. The phases are:

1. Clear every crosspoint to its high-resistance state.
2. Capture the operands into the input latch.
3. Program the minterms.
4. Evaluate the NAND plane and write its results into the AND plane.
5. Evaluate the AND plane.
6. Invert that result to form f.
7. Hand f to the output latch.

Each phase raises its own strobe for a programmable number of cycles. A one-cycle completion pulse follows the last phase, and the sequencer then returns to idle. The analog drivers that turn each strobe into write and read voltages sit outside this block.

In multi-level mode, the programming and NAND-evaluation phases form a loop that runs once per logic level before the AND plane is read. On every level after the first, the block raises a feedback select, so the array driver routes the previous minterm results back in as inputs to later minterms. Software must choose a level count below the number of minterms in the mapped function.

The phase length, the mode and the level count are sampled together with the accepted start. A change to these inputs during a run has no effect until the next start.

States, in order:
- `ST_IDLE`
- `ST_CLEAR`
- `ST_LOAD`
- `ST_CONFIG`
- `ST_NAND`
- `ST_AND`
- `ST_INVERT`
- `ST_EMIT`
- `ST_FINISH`

Transitions:
- `ST_IDLE` moves to `ST_CLEAR` on start.
- Each phase state moves to its successor once its cycle count has elapsed.
- `ST_NAND` goes back to `ST_CONFIG` while levels remain, and to `ST_AND` after the last level.
- `ST_FINISH` always returns to `ST_IDLE` after one cycle.

Top module: `xbar_seq`

## Requirements
- R1: Coming out of reset, busy, done, feedback_sel, level and every strobe bit are 0.
- R2: The first cycle after the clock edge that samples start high in idle shows strobe bit 0. The phases then appear in this order: bit 0 clear, bit 1 load, bit 2 configure, bit 3 NAND evaluate, bit 4 AND evaluate, bit 5 invert, bit 6 emit.
- R3: Each phase holds its strobe for phase_len cycles, and a phase_len of 0 counts as 1. The phase_len, multi_en and num_levels values present at the accepted start govern the whole run, whatever those inputs do later.
- R4: While busy and not done, exactly one strobe bit is high. In idle and in the done cycle, strobe is 0.
- R5: A start pulse that arrives while busy is high, including the done cycle, is ignored. The current run continues unchanged.
- R6: done is high for exactly one cycle, directly after the last emit cycle, with busy also high. The next cycle is idle.
- R7: With multi_en high, the configure and NAND-evaluate phases repeat as a pair num_levels times before the AND phase, and a num_levels of 0 counts as 1. With multi_en low, the pair runs once and num_levels is ignored.
- R8: During the configure and NAND-evaluate phases, level shows the current pass, counting from 0, and feedback_sel is high when that pass is not 0. In all other states, level and feedback_sel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an evaluation; accepted only in idle |
| multi_en | input | 1 | Selects multi-level looping for the run |
| num_levels | input | LVL_W | Number of logic levels in multi-level mode (0 counts as 1) |
| phase_len | input | CNT_W | Cycles per phase (0 counts as 1) |
| strobe | output | 7 | One-hot phase strobe, bit 0 clear through bit 6 emit |
| level | output | LVL_W | Current pass index during the configure/NAND loop |
| feedback_sel | output | 1 | Routes minterm results back as inputs on later levels |
| busy | output | 1 | High from the first phase through the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume a reset that starts low at time zero and assume nothing else about the inputs. Start, mode, level count and phase length may change on any cycle, because the block samples them only when a start is accepted. The stimulus still drives every input half a cycle away from the active edge. It deliberately toggles start, phase_len, num_levels and multi_en in the middle of a run and in the done cycle, which exercises the ignore-while-busy rule and the sample-at-start rule. The zero encodings of phase_len and num_levels are driven on purpose to exercise the rule that 0 counts as 1.

// File: rtl/xbar_seq_pkg.sv
package xbar_seq_pkg;

    localparam int NUM_PHASES = 7;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CLEAR  = 4'd1,
        ST_LOAD   = 4'd2,
        ST_CONFIG = 4'd3,
        ST_NAND   = 4'd4,
        ST_AND    = 4'd5,
        ST_INVERT = 4'd6,
        ST_EMIT   = 4'd7,
        ST_FINISH = 4'd8
    } seq_state_t;

endpackage

// File: rtl/xbar_phase_timer.sv
module xbar_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (cnt_q < len)); // R3

endmodule

// File: rtl/xbar_level_ctr.sv
module xbar_level_ctr #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] limit_in,
    input  logic             step,
    output logic [LVL_W-1:0] lvl,
    output logic             last_lvl
);

    logic [LVL_W-1:0] lim_q;

    assign last_lvl = (lvl == lim_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= LVL_W'(1);
            lvl   <= '0;
        end else if (load) begin
            lim_q <= limit_in;
            lvl   <= '0;
        end else if (step) begin
            lvl   <= lvl + 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lvl < lim_q); // R7

endmodule

// File: rtl/xbar_strobe_dec.sv
module xbar_strobe_dec #(
    parameter int NPH = 7
) (
    input  logic [3:0]     st,
    output logic [NPH-1:0] strobe
);

    for (genvar i = 0; i < NPH; i++) begin : g_dec
        assign strobe[i] = (st == 4'(i + 1));
    end

endmodule

// File: rtl/xbar_seq.sv
module xbar_seq
    import xbar_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi_en,
    input  logic [LVL_W-1:0] num_levels,
    input  logic [CNT_W-1:0] phase_len,
    output logic [6:0]       strobe,
    output logic [LVL_W-1:0] level,
    output logic             feedback_sel,
    output logic             busy,
    output logic             done
);

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] len_q;
    logic [LVL_W-1:0] lim_in;
    logic [LVL_W-1:0] lvl;
    logic             lv_last;
    logic             t_last;
    logic             accept;
    logic             in_phase;
    logic             adv;
    logic             in_loop;

    assign accept   = (st_q == ST_IDLE) && start;
    assign in_phase = (st_q != ST_IDLE) && (st_q != ST_FINISH);
    assign adv      = in_phase && t_last;
    assign lim_in   = !multi_en ? LVL_W'(1) :
                      (num_levels == '0) ? LVL_W'(1) : num_levels;

    // Phase length sampled together with the accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= CNT_W'(1);
        end else if (accept) begin
            len_q <= (phase_len == '0) ? CNT_W'(1) : phase_len;
        end
    end

    xbar_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept || adv),
        .run     (in_phase),
        .len     (len_q),
        .last    (t_last)
    );

    xbar_level_ctr #(.LVL_W(LVL_W)) u_levels (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .limit_in (lim_in),
        .step     ((st_q == ST_NAND) && adv && !lv_last),
        .lvl      (lvl),
        .last_lvl (lv_last)
    );

    xbar_strobe_dec #(.NPH(NUM_PHASES)) u_dec (
        .st     (st_q),
        .strobe (strobe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_CLEAR;
            ST_CLEAR:  if (adv)   st_d = ST_LOAD;
            ST_LOAD:   if (adv)   st_d = ST_CONFIG;
            ST_CONFIG: if (adv)   st_d = ST_NAND;
            ST_NAND:   if (adv)   st_d = lv_last ? ST_AND : ST_CONFIG;
            ST_AND:    if (adv)   st_d = ST_INVERT;
            ST_INVERT: if (adv)   st_d = ST_EMIT;
            ST_EMIT:   if (adv)   st_d = ST_FINISH;
            ST_FINISH:            st_d = ST_IDLE;
            default:              st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy         = (st_q != ST_IDLE);
        done         = (st_q == ST_FINISH);
        in_loop      = (st_q == ST_CONFIG) || (st_q == ST_NAND);
        level        = in_loop ? lvl : '0;
        feedback_sel = in_loop && (lvl != '0);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> ($countones(strobe) == 1)); // R4
    AST_QUIET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> (strobe == '0)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(strobe[6])); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe[0]) |-> $past(!busy)); // R5
    AST_AND_AFTER_NAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe[4]) |-> $past(strobe[3])); // R7
    AST_FB_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        feedback_sel |-> (strobe[2] || strobe[3])); // R8

endmodule

// File: tb/test_xbar_seq.sv
module test_xbar_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int LVL_W = 4;

    typedef struct packed {
        logic [6:0]       stb;
        logic             dn;
        logic             bz;
        logic [LVL_W-1:0] lv;
        logic             fb;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             multi_en = 1'b0;
    logic [LVL_W-1:0] num_levels = '0;
    logic [CNT_W-1:0] phase_len = '0;
    logic [6:0]       strobe;
    logic [LVL_W-1:0] level;
    logic             feedback_sel;
    logic             busy;
    logic             done;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_seq #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_xbar_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multi_en     (multi_en),
        .num_levels   (num_levels),
        .phase_len    (phase_len),
        .strobe       (strobe),
        .level        (level),
        .feedback_sel (feedback_sel),
        .busy         (busy),
        .done         (done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_phase(input int p, input int len, input int lv);
        for (int c = 0; c < len; c++) begin
            item_t it;
            it.stb = 7'(1 << p);
            it.dn  = 1'b0;
            it.bz  = 1'b1;
            it.lv  = LVL_W'(lv);
            it.fb  = (lv != 0);
            exp_q.push_back(it);
        end
    endtask

    // Driver: pushes expected items per cycle, then runs the stimulus.
    task automatic run(input int len, input bit multi, input int nlev, input bit disturb);
        int l_eff, v_eff, total;
        item_t it;
        l_eff = (len == 0) ? 1 : len;
        v_eff = !multi ? 1 : ((nlev == 0) ? 1 : nlev);
        @(negedge clk);
        phase_len  = CNT_W'(len);
        multi_en   = multi;
        num_levels = LVL_W'(nlev);
        start      = 1'b1;
        push_phase(0, l_eff, 0);                       // R2 clear
        push_phase(1, l_eff, 0);                       // R2 load
        for (int v = 0; v < v_eff; v++) begin          // R7 loop
            push_phase(2, l_eff, v);
            push_phase(3, l_eff, v);
        end
        push_phase(4, l_eff, 0);
        push_phase(5, l_eff, 0);
        push_phase(6, l_eff, 0);
        it = '0; it.dn = 1'b1; it.bz = 1'b1;           // R6 done cycle
        exp_q.push_back(it);
        it = '0;                                       // back to idle
        exp_q.push_back(it);
        total = exp_q.size();
        for (int j = 1; j < total; j++) begin
            @(negedge clk);
            start = disturb && (j == 2 || j == total - 1);   // R5
            if (disturb && j == 2) begin                     // R3 latched
                phase_len  = CNT_W'(l_eff + 3);
                num_levels = LVL_W'(nlev + 2);
                multi_en   = ~multi;
            end
        end
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                item_t e;
                e = exp_q.pop_front();
                check("R2 R3 R4 strobe", int'(strobe), int'(e.stb));
                check("R6 done",         int'(done),   int'(e.dn));
                check("R5 R6 busy",      int'(busy),   int'(e.bz));
                check("R7 R8 level",     int'(level),  int'(e.lv));
                check("R8 feedback_sel", int'(feedback_sel), int'(e.fb));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 strobe", int'(strobe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 level", int'(level), 0);
        check("R1 feedback_sel", int'(feedback_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset release", int'(busy), 0);

        run(1, 1'b0, 0, 1'b0);   // R2 shortest phases
        run(3, 1'b0, 5, 1'b0);   // R3 longer phases, R7 levels ignored
        run(0, 1'b1, 3, 1'b0);   // R3 zero length, R7 three levels
        run(2, 1'b1, 0, 1'b0);   // R7 zero levels counts as one
        run(2, 1'b1, 2, 1'b1);   // R5 ignored start, R3 late input changes
        run(4, 1'b0, 0, 1'b1);   // R5 start during done cycle

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule